// File: doc/BRIEF.md
# Low-Power Mode and Clock-Gating Controller

This block decides which operating mode a small microcontroller core is in and turns that decision into clock enables. While the core runs, the mode is either NORMAL or SLOW. NORMAL takes the high-speed clock through a power-of-two divider. SLOW passes the low-speed clock straight through. A halt request from the CPU moves the block into one of four low-power modes. The choice depends on three things: the idle-enable bit, the keep-system-clock bit, and whether the low-voltage detector or a watchdog on the sub clock still needs that clock.

A wake event returns the block to a running mode. If the system oscillator had been stopped, the CPU clock stays gated for a fixed settle interval first. Oscillators, the watchdog, the voltage detector and the CPU are outside the block. The block only drives their enables and receives their strobes. The asynchronous reset is released through a two-stage synchronizer, so internal state leaves reset two clock edges after `rst_n` rises.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the block is in NORMAL (mode code 0) with `cpu_clk_en`, `sysosc_en`, `fsub_en` and `fs_en` all 1.
- R2: While running and not halting, the mode code one cycle later is 0 (NORMAL) when `clk_sel_hi` is 1 and 1 (SLOW) when it is 0.
- R3: A halt with `idle_en`=0 gives mode 3 (SLEEP1) on the next cycle if `lvd_en`=1 or (`wdt_en`=1 and `fs_src_sub`=1). Otherwise it gives mode 2 (SLEEP0).
- R4: A halt with `idle_en`=1 gives mode 5 (IDLE1) on the next cycle if `sysclk_keep`=1, and mode 4 (IDLE0) if `sysclk_keep`=0.
- R5: `cpu_clk_en` is 0 in every low-power mode. `sysosc_en` is 1 only in NORMAL, SLOW and IDLE1. `fsub_en` is 0 only in SLEEP0.
- R6: `fs_en` follows `fsub_en` when `fs_src_sub`=1 (fS from the sub clock) and follows `sysosc_en` when `fs_src_sub`=0 (fS from the system clock divided by 4). As a result, in IDLE0 fS is on only when its source is the sub clock.
- R7: In a low-power mode, or while the settle count runs, `halt_req` and changes to the control bits leave the mode code unchanged.
- R8: A `wake` pulse in a low-power mode gives, on the next cycle, mode 0 or 1 according to `clk_sel_hi`, with `sysosc_en`=1.
- R9: After a wake from SLEEP0, SLEEP1 or IDLE0, `cpu_clk_en` stays 0 for exactly 8 cycles. After a wake from IDLE1 it is 1 on the first running cycle.
- R10: In NORMAL with the CPU clock on, `sysclk_div_en` pulses for one cycle every 2^`div_sel` cycles for `div_sel` 0 to 6. Code 7 gives a period of 64.
- R11: A new `div_sel` value takes effect only after the pulse that ends the current divider period.
- R12: In SLOW with the CPU clock on, `sysclk_div_en` is 1 on every cycle. In low-power modes and during the settle count it is 0.
- R13: A `wake` pulse while running leaves the mode code and `cpu_clk_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request strobe from the CPU |
| wake | input | 1 | Wake event (interrupt or reset-class) |
| idle_en | input | 1 | 1: halt enters an idle mode; 0: halt enters a sleep mode |
| sysclk_keep | input | 1 | 1: system oscillator keeps running in idle |
| clk_sel_hi | input | 1 | 1: high-speed clock (NORMAL); 0: low-speed clock (SLOW) |
| div_sel | input | 3 | Divider code, ratio 2^code, saturated at 64 |
| lvd_en | input | 1 | Low-voltage detector enabled |
| wdt_en | input | 1 | Watchdog enabled |
| fs_src_sub | input | 1 | 1: fS and the watchdog run from the sub clock; 0: from system clock / 4 |
| mode | output | 3 | Current mode code (0 to 5) |
| cpu_clk_en | output | 1 | CPU clock enable |
| sysosc_en | output | 1 | System oscillator enable |
| sysclk_div_en | output | 1 | Divided system clock enable pulse |
| fsub_en | output | 1 | Sub clock domain enable |
| fs_en | output | 1 | fS clock domain enable |

## Verification
Mode changes caused by `halt_req`, `wake` or `clk_sel_hi` are registered once, so the new mode code and enables are due one cycle after the stimulus. The bench drives each input on a falling edge and checks at the next falling edge. After a wake, the bench counts falling edges until `cpu_clk_en` rises and compares that count with 8 or 0. Divider periods are measured as the number of falling edges between two observed pulses, after first letting one pulse pass so that the requested ratio has been loaded.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_SLOW   = 3'd1,
    MODE_SLEEP0 = 3'd2,
    MODE_SLEEP1 = 3'd3,
    MODE_IDLE0  = 3'd4,
    MODE_IDLE1  = 3'd5
  } lpm_mode_e;

  function automatic logic mode_is_run(lpm_mode_e m);
    return (m == MODE_NORMAL) || (m == MODE_SLOW);
  endfunction

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      wake,
  input  logic      idle_en,
  input  logic      sysclk_keep,
  input  logic      clk_sel_hi,
  input  logic      lvd_en,
  input  logic      wdt_en,
  input  logic      fs_src_sub,
  output lpm_mode_e mode_q,
  output logic      settling
);

  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SETTLE_LOAD = SET_W'(SETTLE_CYC);

  lpm_mode_e        mode_d;
  logic [SET_W-1:0] settle_q, settle_d;
  lpm_mode_e        run_target;
  logic             sub_needed;

  assign run_target = clk_sel_hi ? MODE_NORMAL : MODE_SLOW;
  assign sub_needed = lvd_en || (wdt_en && fs_src_sub);
  assign settling   = (settle_q != '0);

  always_comb begin
    mode_d   = mode_q;
    settle_d = settling ? (settle_q - SET_W'(1)) : '0;
    if (mode_is_run(mode_q)) begin
      if (halt_req && !settling) begin
        if (idle_en) mode_d = sysclk_keep ? MODE_IDLE1 : MODE_IDLE0;
        else         mode_d = sub_needed  ? MODE_SLEEP1 : MODE_SLEEP0;
      end else begin
        mode_d = run_target;
      end
    end else if (wake) begin
      mode_d   = run_target;
      settle_d = (mode_q == MODE_IDLE1) ? '0 : SETTLE_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_NORMAL;
      settle_q <= '0;
    end else begin
      mode_q   <= mode_d;
      settle_q <= settle_d;
    end
  end

  assert_halt_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_is_run(mode_q) && !wake) |=> $stable(mode_q));

  assert_settle_halt_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_run(mode_q) && settling) |=> mode_is_run(mode_q));

  assert_sleep_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_run(mode_q) && !settling && halt_req && !idle_en)
      |=> (mode_q == (($past(lvd_en) || ($past(wdt_en) && $past(fs_src_sub)))
                      ? MODE_SLEEP1 : MODE_SLEEP0)));

  assert_idle_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_run(mode_q) && !settling && halt_req && idle_en)
      |=> (mode_q == ($past(sysclk_keep) ? MODE_IDLE1 : MODE_IDLE0)));

  assert_wake_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_is_run(mode_q) && wake) |=> (mode_is_run(mode_q) && !$stable(mode_q)));

  assert_settle_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_is_run(mode_q) && wake && mode_q != MODE_IDLE1) |=> (settle_q == SETTLE_LOAD));

  assert_settle_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_q <= SETTLE_LOAD);

endmodule

// File: rtl/lpm_enable_map.sv
module lpm_enable_map
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpm_mode_e mode_q,
  input  logic      settling,
  input  logic      fs_src_sub,
  output logic      cpu_clk_en,
  output logic      sysosc_en,
  output logic      fsub_en,
  output logic      fs_en,
  output logic      div_run,
  output logic      slow_run
);

  logic running;

  assign running = mode_is_run(mode_q);

  always_comb begin
    cpu_clk_en = running && !settling;
    sysosc_en  = running || (mode_q == MODE_IDLE1);
    fsub_en    = (mode_q != MODE_SLEEP0);
    fs_en      = fs_src_sub ? fsub_en : sysosc_en;
    div_run    = (mode_q == MODE_NORMAL) && !settling;
    slow_run   = (mode_q == MODE_SLOW) && !settling;
  end

  assert_cpu_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (div_run || slow_run));

  assert_sleep0_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP0) |-> (!fsub_en && !fs_en && !sysosc_en));

  assert_idle0_fs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE0) |-> (fs_en == fs_src_sub));

endmodule

// File: rtl/lpm_clk_divider.sv
module lpm_clk_divider #(
  parameter int DIV_SEL_W = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 bypass,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);

  localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
  localparam int SEL_MAX = (1 << DIV_SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_q, term_d;
  logic [CNT_W-1:0] term_req;
  int               shift_eff;

  generate
    if (SEL_MAX > MAX_SHIFT) begin : g_clamp
      assign shift_eff = (int'(div_sel) > MAX_SHIFT) ? MAX_SHIFT : int'(div_sel);
    end else begin : g_direct
      assign shift_eff = int'(div_sel);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < CNT_W; i++) term_req[i] = (i < shift_eff);
  end

  always_comb begin
    cnt_d  = cnt_q;
    term_d = term_q;
    if (!run || (cnt_q == term_q)) begin
      cnt_d  = '0;
      term_d = term_req;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      term_q <= term_d;
    end
  end

  assign tick = (run && (cnt_q == term_q)) || bypass;

  assert_tick_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (run || bypass));

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= term_q));

  assert_ratio_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != term_q) |=> $stable(term_q));

endmodule

// File: rtl/lpm_clkgate_ctrl.sv
module lpm_clkgate_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int DIV_SEL_W  = 3,
  parameter int MAX_SHIFT  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req,
  input  logic                 wake,
  input  logic                 idle_en,
  input  logic                 sysclk_keep,
  input  logic                 clk_sel_hi,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 lvd_en,
  input  logic                 wdt_en,
  input  logic                 fs_src_sub,
  output logic [2:0]           mode,
  output logic                 cpu_clk_en,
  output logic                 sysosc_en,
  output logic                 sysclk_div_en,
  output logic                 fsub_en,
  output logic                 fs_en
);

  logic      rst_int_n;
  lpm_mode_e mode_q;
  logic      settling;
  logic      div_run;
  logic      slow_run;

  lpm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lpm_mode_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .halt_req    (halt_req),
    .wake        (wake),
    .idle_en     (idle_en),
    .sysclk_keep (sysclk_keep),
    .clk_sel_hi  (clk_sel_hi),
    .lvd_en      (lvd_en),
    .wdt_en      (wdt_en),
    .fs_src_sub  (fs_src_sub),
    .mode_q      (mode_q),
    .settling    (settling)
  );

  lpm_enable_map u_map (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_q     (mode_q),
    .settling   (settling),
    .fs_src_sub (fs_src_sub),
    .cpu_clk_en (cpu_clk_en),
    .sysosc_en  (sysosc_en),
    .fsub_en    (fsub_en),
    .fs_en      (fs_en),
    .div_run    (div_run),
    .slow_run   (slow_run)
  );

  lpm_clk_divider #(.DIV_SEL_W(DIV_SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (div_run),
    .bypass  (slow_run),
    .div_sel (div_sel),
    .tick    (sysclk_div_en)
  );

  assign mode = mode_q;

  assert_wake_no_effect_R13: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_clk_en && !halt_req && $stable(clk_sel_hi)) |=> cpu_clk_en);

endmodule

// File: tb/lpm_clkgate_ctrl_test.sv
module lpm_clkgate_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt_req, wake, idle_en, sysclk_keep, clk_sel_hi;
  logic [2:0] div_sel;
  logic       lvd_en, wdt_en, fs_src_sub;
  logic [2:0] mode;
  logic       cpu_clk_en, sysosc_en, sysclk_div_en, fsub_en, fs_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lpm_clkgate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake(wake),
    .idle_en(idle_en), .sysclk_keep(sysclk_keep), .clk_sel_hi(clk_sel_hi),
    .div_sel(div_sel), .lvd_en(lvd_en), .wdt_en(wdt_en), .fs_src_sub(fs_src_sub),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .sysosc_en(sysosc_en),
    .sysclk_div_en(sysclk_div_en), .fsub_en(fsub_en), .fs_en(fs_en)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sysclk_div_en && n < 200);
  endtask

  task automatic halt_pulse();
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
  endtask

  task automatic wake_pulse();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  task automatic count_settle(output int n);
    n = 0;
    while (!cpu_clk_en && n < 30) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    int exp_mode;
    rst_n = 1'b0; halt_req = 1'b0; wake = 1'b0; idle_en = 1'b0;
    sysclk_keep = 1'b0; clk_sel_hi = 1'b1; div_sel = 3'd0;
    lvd_en = 1'b0; wdt_en = 1'b0; fs_src_sub = 1'b0;
    tick_n(3);
    // R1: state while reset is held
    chk("R1 mode in reset", mode, 0);
    chk("R1 cpu_clk_en in reset", cpu_clk_en, 1);
    rst_n = 1'b1;
    tick_n(4);
    chk("R1 mode after reset", mode, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 sysosc_en", sysosc_en, 1);
    chk("R1 fsub_en", fsub_en, 1);
    chk("R1 fs_en", fs_en, 1);

    // Sweep: every low-power entry for both run selections
    for (int sel = 0; sel < 2; sel++) begin
      for (int cfg = 0; cfg < 32; cfg++) begin
        idle_en     = cfg[0];
        sysclk_keep = cfg[1];
        lvd_en      = cfg[2];
        wdt_en      = cfg[3];
        fs_src_sub  = cfg[4];
        clk_sel_hi  = sel[0];
        @(negedge clk);
        chk("R2 run mode follows clk_sel_hi", mode, sel ? 0 : 1);
        halt_pulse();
        if (cfg[0]) exp_mode = cfg[1] ? 5 : 4;
        else        exp_mode = (cfg[2] || (cfg[3] && cfg[4])) ? 3 : 2;
        chk(cfg[0] ? "R4 idle entry" : "R3 sleep entry", mode, exp_mode);
        chk("R5 cpu_clk_en off", cpu_clk_en, 0);
        chk("R5 sysosc_en", sysosc_en, exp_mode == 5);
        chk("R5 fsub_en", fsub_en, exp_mode != 2);
        chk("R6 fs_en", fs_en, cfg[4] ? (exp_mode != 2) : (exp_mode == 5));
        chk("R12 no pulse in low power", sysclk_div_en, 0);
        // R7: halt and control changes ignored
        idle_en = ~idle_en; sysclk_keep = ~sysclk_keep; lvd_en = ~lvd_en;
        clk_sel_hi = ~clk_sel_hi;
        halt_pulse();
        chk("R7 halt ignored in low power", mode, exp_mode);
        idle_en = cfg[0]; sysclk_keep = cfg[1]; lvd_en = cfg[2];
        clk_sel_hi = sel[0];
        wake_pulse();
        chk("R8 wake run mode", mode, sel ? 0 : 1);
        chk("R8 sysosc_en after wake", sysosc_en, 1);
        if (exp_mode != 5) chk("R12 no pulse while settling", sysclk_div_en, 0);
        count_settle(n);
        chk("R9 settle length", n, (exp_mode == 5) ? 0 : 8);
      end
    end

    // R13: wake while running
    clk_sel_hi = 1'b1;
    tick_n(2);
    wake_pulse();
    chk("R13 mode after wake in run", mode, 0);
    chk("R13 cpu_clk_en after wake in run", cpu_clk_en, 1);

    // R7: halt during settle ignored, settle length unchanged
    idle_en = 1'b0; lvd_en = 1'b0; wdt_en = 1'b0;
    halt_pulse();
    chk("R3 SLEEP0 entry", mode, 2);
    wake_pulse();
    halt_pulse();
    chk("R7 halt ignored while settling", mode, 0);
    count_settle(n);
    chk("R7 settle after ignored halt", n + 1, 8);

    // R10: divider period sweep in NORMAL
    for (int k = 0; k < 8; k++) begin
      div_sel = k[2:0];
      @(negedge clk);
      wait_pulse(n);
      wait_pulse(n);
      chk("R10 divider period", n, 1 << ((k > 6) ? 6 : k));
    end

    // R11: ratio change waits for rollover
    div_sel = 3'd6;
    @(negedge clk);
    wait_pulse(n);
    wait_pulse(n);
    tick_n(5);
    div_sel = 3'd1;
    wait_pulse(n);
    chk("R11 old period kept", n + 5, 64);
    wait_pulse(n);
    chk("R11 new period", n, 2);

    // R12: SLOW passes every cycle
    clk_sel_hi = 1'b0;
    tick_n(2);
    for (int i = 0; i < 4; i++) begin
      chk("R12 slow pulse every cycle", sysclk_div_en, 1);
      @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule